// File: doc/BRIEF.md
# UART Register and Interrupt Front-End

This block is the memory-mapped register face of a serial port whose character path is idealised: bytes move to and from an attached terminal at once, with no bit timing and no queueing. A bus master reads and writes the configuration registers (control, integer and fractional baud divisors, line control, FIFO level select), pushes transmit bytes through the data register, and pulls received bytes from it. The terminal offers one received byte at a time on a valid/data pair and drops it when the block pulses its consume output.

Interrupts run through a raw status register, an enable mask and a masked status register. Only three sources exist: receive, receive timeout and transmit. A single pending timer defers every interrupt evaluation by `INT_DELAY` clock cycles after the event that asked for it; while it runs, further requests are absorbed into it rather than restarting it. A clear register removes raw bits and can drop the interrupt line at once. An optional end-of-transmission option pulses an output whenever byte 0x04 is sent.

Top module: `uart_regfront`

## Requirements
- R1: After reset the control register reads 0x300, the FIFO level select register reads 0x12, and every other register (divisors, line control, mask, raw status, masked status) reads 0; `irq`, `tx_valid` and `eot_pulse` are low.
- R2: The flag register (offset 0x018) always reads with bit 7 (transmit empty) and bit 0 (clear to send) set, and with bit 4 (receive empty) set exactly when `rx_valid` is low; all other bits read 0.
- R3: A data register (offset 0x000) read returns `rx_data` and pulses `rx_take` in the same cycle when `rx_valid` is high; with `rx_valid` low it returns 0 and `rx_take` stays low.
- R4: A data register write presents the low 8 write-data bits on `tx_data` with `tx_valid` high for exactly the cycle after the write, and sets raw status bit 5 (TX) whatever the mask holds.
- R5: A rising edge of `rx_valid` sets raw status bits 4 (RX) and 6 (RX timeout) and requests an interrupt evaluation.
- R6: A mask register (offset 0x038) write whose truncated data has any bit other than 4, 5 or 6 set raises `bus_err` and leaves the mask unchanged; an accepted write with bit 5 set also sets raw bit 5 and requests an evaluation.
- R7: An evaluation happens on the clock edge `INT_DELAY` cycles after the edge of the request that started the timer; a request arriving while the timer runs neither restarts nor extends it.
- R8: At an evaluation the masked status (offset 0x040) takes mask AND raw status (offset 0x03C), and `irq` becomes high if masked bit 4, 5 or 6 is set and low otherwise.
- R9: A clear register (offset 0x044) write removes every raw bit whose write-data bit is 1 and recomputes the masked status; if that result is zero, `irq` is low from the next cycle. A clear landing on the same edge as an evaluation is applied first, so the evaluation sees the cleared raw bits.
- R10: `bus_size` gives the access width in bytes: 1, 2 or 4 are accepted, write data is truncated to that width before storing (control and integer divisor keep 16 bits, line control 8, fractional divisor and level select 6), and read data is truncated to the same width. Offsets 0x024, 0x028, 0x02C, 0x030 and 0x034 hold the integer divisor, fractional divisor, line control, control and level select.
- R11: Any other size, an unmapped offset, a write to the flag, raw or masked status register, a read of the clear register, or a read and write in the same cycle raises `bus_err` in that cycle, returns 0 and changes no state.
- R12: With `eot_enable` high, a data register write of byte 0x04 pulses `eot_pulse` for one cycle together with `tx_valid`; with `eot_enable` low, or for any other byte, `eot_pulse` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_size | input | 3 | Access width in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| bus_err | output | 1 | Access rejected, valid in the strobe cycle |
| rx_valid | input | 1 | Terminal has a received byte pending |
| rx_data | input | 8 | Pending received byte |
| rx_take | output | 1 | Pending byte consumed this cycle |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| eot_enable | input | 1 | Enables the end-of-transmission pulse |
| eot_pulse | output | 1 | End-of-transmission byte was sent |
| irq | output | 1 | Level interrupt |

## Verification
The two functions that can meet on one edge are the end of the pending timer and a clear register write. The bench arms the timer by enabling the TX source, then times a clear of raw bit 5 so that its strobe edge is exactly the evaluation edge; the interrupt must stay low and the masked status must read 0, which shows the clear was applied before the evaluation. A second timing probe writes the data register while the timer runs and checks that the interrupt rises on the edge set by the first request, not one cycle later.

// File: rtl/uart_regfront_pkg.sv
// Package: shared register selects and interrupt bit positions for the
// UART register front-end. Assumes a 16-bit wide register file.
package uart_regfront_pkg;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_FLAG, SEL_IDIV, SEL_FDIV, SEL_LINE,
        SEL_CTRL, SEL_LVL, SEL_MASK, SEL_RAW, SEL_MSKD, SEL_CLR
    } reg_sel_e;

    localparam int IRQ_W  = 11;
    localparam int BIT_RX = 4;
    localparam int BIT_TX = 5;
    localparam int BIT_RT = 6;

    localparam logic [IRQ_W-1:0] SRC_BITS     = 11'h070;
    localparam logic [15:0]      MASK_ALLOWED = 16'h0070;

endpackage

// File: rtl/uart_regfront_decode.sv
// Module: access decoder. Maps an offset to a register select, checks the
// access width, truncates write data and flags illegal accesses.
// Assumes one strobe per access; all state changes are gated by the top
// with the returned ok strobes.
module uart_regfront_decode
    import uart_regfront_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [2:0]        size,
    input  logic [31:0]       wdata,
    output reg_sel_e          sel,
    output logic [15:0]       wdata_t,
    output logic [31:0]       rd_mask,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              err
);

    logic        size_ok;
    logic        bad_ro;
    logic        bad_mask;
    logic        unused_hi;

    assign unused_hi = ^wdata[31:16];

    // Offset to register select.
    always_comb begin
        case (addr)
            ADDR_W'(12'h000): sel = SEL_DATA;
            ADDR_W'(12'h018): sel = SEL_FLAG;
            ADDR_W'(12'h024): sel = SEL_IDIV;
            ADDR_W'(12'h028): sel = SEL_FDIV;
            ADDR_W'(12'h02C): sel = SEL_LINE;
            ADDR_W'(12'h030): sel = SEL_CTRL;
            ADDR_W'(12'h034): sel = SEL_LVL;
            ADDR_W'(12'h038): sel = SEL_MASK;
            ADDR_W'(12'h03C): sel = SEL_RAW;
            ADDR_W'(12'h040): sel = SEL_MSKD;
            ADDR_W'(12'h044): sel = SEL_CLR;
            default:          sel = SEL_NONE;
        endcase
    end

    // Width check and truncation masks.
    always_comb begin
        size_ok = 1'b1;
        case (size)
            3'd1:    rd_mask = 32'h0000_00FF;
            3'd2:    rd_mask = 32'h0000_FFFF;
            3'd4:    rd_mask = 32'hFFFF_FFFF;
            default: begin
                rd_mask = 32'h0;
                size_ok = 1'b0;
            end
        endcase
        wdata_t = wdata[15:0] & rd_mask[15:0];
    end

    // Illegal access classification.
    always_comb begin
        bad_ro   = wr && (sel == SEL_FLAG || sel == SEL_RAW || sel == SEL_MSKD);
        bad_mask = wr && (sel == SEL_MASK) && (|(wdata_t & ~MASK_ALLOWED));
        err      = (rd || wr) && (!size_ok || sel == SEL_NONE || (rd && wr) ||
                   bad_ro || bad_mask || (rd && sel == SEL_CLR));
        rd_ok    = rd && !err;
        wr_ok    = wr && !err;
    end

endmodule

// File: rtl/uart_regfront_irq.sv
// Module: interrupt core. Holds mask, raw and masked status, the single
// non-rearming evaluation timer and the interrupt level. Assumes
// INT_DELAY >= 1 and that set and clear requests are one-cycle strobes.
module uart_regfront_irq
    import uart_regfront_pkg::*;
#(
    parameter int INT_DELAY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_rx,
    input  logic             set_tx,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] mask_wdata,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_data,
    output logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);

    localparam int CNT_W = $clog2(INT_DELAY + 1);

    logic [CNT_W-1:0] cnt;
    logic             pending;
    logic             eval;
    logic             trigger;
    logic [IRQ_W-1:0] sets;
    logic [IRQ_W-1:0] raw_next;
    logic [IRQ_W-1:0] mask_next;
    logic [IRQ_W-1:0] masked_next;

    // Next-state of status: clears first, then same-cycle sets.
    always_comb begin
        sets          = '0;
        sets[BIT_RX]  = set_rx;
        sets[BIT_RT]  = set_rx;
        sets[BIT_TX]  = set_tx || (mask_we && mask_wdata[BIT_TX]);
        trigger       = set_rx || sets[BIT_TX];
        raw_next      = (raw & ~(clr_we ? clr_data : '0)) | sets;
        mask_next     = mask_we ? mask_wdata : mask;
        masked_next   = mask_next & raw_next;
        eval          = pending && (cnt == '0);
    end

    // Status registers and interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            raw    <= '0;
            masked <= '0;
            irq    <= 1'b0;
        end else begin
            mask <= mask_next;
            raw  <= raw_next;
            if (eval || clr_we) masked <= masked_next;
            if (eval)
                irq <= |(masked_next & SRC_BITS);
            else if (clr_we && masked_next == '0)
                irq <= 1'b0;
        end
    end

    // Evaluation timer: started only when idle or expiring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            cnt     <= '0;
        end else if (trigger && (!pending || eval)) begin
            pending <= 1'b1;
            cnt     <= CNT_W'(INT_DELAY - 1);
        end else if (eval) begin
            pending <= 1'b0;
        end else if (pending) begin
            cnt <= cnt - 1'b1;
        end
    end

    p_tx_raw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_tx |=> raw[BIT_TX]);

    p_rx_raw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_rx |=> (raw[BIT_RX] && raw[BIT_RT]));

    p_timer_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (cnt < CNT_W'(INT_DELAY)));

    p_rise_at_eval_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(eval));

    p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !eval && masked_next == '0) |=> !irq);

endmodule

// File: rtl/uart_regfront.sv
// Module: UART register front-end top. Holds the configuration registers,
// the read mux, the transmit byte strobe and the end-of-transmission pulse,
// and wires the decoder and interrupt core. Assumes the terminal drops
// rx_valid after rx_take and presents at most one byte at a time.
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int INT_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [2:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_take,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              eot_enable,
    output logic              eot_pulse,
    output logic              irq
);

    reg_sel_e         sel;
    logic [15:0]      wd;
    logic [31:0]      rd_mask;
    logic             rd_ok;
    logic             wr_ok;
    logic [15:0]      ctrl_q;
    logic [15:0]      idiv_q;
    logic [5:0]       fdiv_q;
    logic [7:0]       line_q;
    logic [5:0]       lvl_q;
    logic             rx_q;
    logic             data_we;
    logic [IRQ_W-1:0] mask;
    logic [IRQ_W-1:0] raw;
    logic [IRQ_W-1:0] masked;
    logic [31:0]      rd_raw;

    uart_regfront_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .size(bus_size),
        .wdata(bus_wdata), .sel(sel), .wdata_t(wd), .rd_mask(rd_mask),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .err(bus_err)
    );

    assign data_we = wr_ok && (sel == SEL_DATA);
    assign rx_take = rd_ok && (sel == SEL_DATA) && rx_valid;

    uart_regfront_irq #(.INT_DELAY(INT_DELAY)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_rx(rx_valid && !rx_q), .set_tx(data_we),
        .mask_we(wr_ok && (sel == SEL_MASK)), .mask_wdata(wd[IRQ_W-1:0]),
        .clr_we(wr_ok && (sel == SEL_CLR)), .clr_data(wd[IRQ_W-1:0]),
        .mask(mask), .raw(raw), .masked(masked), .irq(irq)
    );

    // Configuration registers, written only by accepted accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 16'h0300;
            idiv_q <= '0;
            fdiv_q <= '0;
            line_q <= '0;
            lvl_q  <= 6'h12;
        end else if (wr_ok) begin
            case (sel)
                SEL_CTRL: ctrl_q <= wd;
                SEL_IDIV: idiv_q <= wd;
                SEL_FDIV: fdiv_q <= wd[5:0];
                SEL_LINE: line_q <= wd[7:0];
                SEL_LVL:  lvl_q  <= wd[5:0];
                default:  ;
            endcase
        end
    end

    // Transmit strobe, end-of-transmission pulse and receive edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid  <= 1'b0;
            tx_data   <= '0;
            eot_pulse <= 1'b0;
            rx_q      <= 1'b0;
        end else begin
            tx_valid  <= data_we;
            eot_pulse <= data_we && eot_enable && (wd[7:0] == 8'h04);
            rx_q      <= rx_valid;
            if (data_we) tx_data <= wd[7:0];
        end
    end

    // Read mux, truncated to the access width.
    always_comb begin
        case (sel)
            SEL_DATA: rd_raw = {24'b0, rx_valid ? rx_data : 8'h00};
            SEL_FLAG: rd_raw = {24'b0, 1'b1, 2'b0, !rx_valid, 3'b0, 1'b1};
            SEL_IDIV: rd_raw = {16'b0, idiv_q};
            SEL_FDIV: rd_raw = {26'b0, fdiv_q};
            SEL_LINE: rd_raw = {24'b0, line_q};
            SEL_CTRL: rd_raw = {16'b0, ctrl_q};
            SEL_LVL:  rd_raw = {26'b0, lvl_q};
            SEL_MASK: rd_raw = {21'b0, mask};
            SEL_RAW:  rd_raw = {21'b0, raw};
            SEL_MSKD: rd_raw = {21'b0, masked};
            default:  rd_raw = 32'h0;
        endcase
        bus_rdata = rd_ok ? (rd_raw & rd_mask) : 32'h0;
    end

    p_take_needs_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> (rx_valid && bus_rd));

    p_tx_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |=> tx_valid);

    p_err_no_cfg_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> ($stable(ctrl_q) && $stable(idiv_q) && $stable(line_q) &&
                     $stable(mask)));

    p_eot_with_tx_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eot_pulse |-> (tx_valid && tx_data == 8'h04));

endmodule

// File: tb/uart_regfront_test.sv
// Bench: scoreboard. The access task pushes the expected read data, error
// and consume flags into a queue; a monitor pops and compares them while
// each access is on the bus. Timing checks on irq and tx are direct.
module uart_regfront_test;

    localparam int DLY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_size = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_take;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        eot_enable = 1'b0;
    logic        eot_pulse;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] d;
        logic        e;
        logic        t;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    uart_regfront #(.ADDR_W(12), .INT_DELAY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_take(rx_take), .tx_valid(tx_valid),
        .tx_data(tx_data), .eot_enable(eot_enable), .eot_pulse(eot_pulse),
        .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Called right after a falling edge; returns at the next falling edge.
    task automatic acc(input logic w, input logic [11:0] a, input logic [2:0] sz,
                       input logic [31:0] wd, input logic [31:0] ed,
                       input logic ee, input logic et, input string tag);
        exp_t x;
        x.d = ed; x.e = ee; x.t = et; x.tag = tag;
        sbq.push_back(x);
        bus_addr = a; bus_size = sz; bus_wdata = wd;
        bus_wr = w; bus_rd = !w;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] wd, input string tag);
        acc(1'b1, a, 3'd4, wd, 32'h0, 1'b0, 1'b0, tag);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] ed, input string tag);
        acc(1'b0, a, 3'd4, 32'h0, ed, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compares each bus access against the queue head.
    always @(negedge clk) begin
        #1;
        if (bus_rd || bus_wr) begin
            if (sbq.size() == 0) begin
                chk("scoreboard empty", 32'h1, 32'h0);
            end else begin
                exp_t x;
                x = sbq.pop_front();
                chk({x.tag, " rdata"}, bus_rdata, x.d);
                chk({x.tag, " err"}, {31'b0, bus_err}, {31'b0, x.e});
                chk({x.tag, " take"}, {31'b0, rx_take}, {31'b0, x.t});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R2 flags with nothing pending
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        rd(12'h030, 32'h300, "R1 ctrl");
        rd(12'h034, 32'h12, "R1 level");
        rd(12'h024, 32'h0, "R1 idiv");
        rd(12'h038, 32'h0, "R1 mask");
        rd(12'h03C, 32'h0, "R1 raw");
        rd(12'h040, 32'h0, "R1 masked");
        rd(12'h018, 32'h91, "R2 flags empty");

        // R10 widths and truncation
        wr(12'h024, 32'h1234_ABCD, "R10 idiv w4");
        rd(12'h024, 32'hABCD, "R10 idiv rb");
        acc(1'b1, 12'h02C, 3'd1, 32'h0055_AA77, 32'h0, 1'b0, 1'b0, "R10 line w1");
        rd(12'h02C, 32'h77, "R10 line rb");
        acc(1'b1, 12'h030, 3'd2, 32'h0001_2345, 32'h0, 1'b0, 1'b0, "R10 ctrl w2");
        acc(1'b0, 12'h030, 3'd1, 32'h0, 32'h45, 1'b0, 1'b0, "R10 ctrl r1");
        wr(12'h028, 32'hFF, "R10 fdiv w");
        rd(12'h028, 32'h3F, "R10 fdiv rb");

        // R11 illegal accesses leave state alone
        acc(1'b1, 12'h030, 3'd3, 32'h5555, 32'h0, 1'b1, 1'b0, "R11 size3");
        acc(1'b0, 12'h004, 3'd4, 32'h0, 32'h0, 1'b1, 1'b0, "R11 unmapped");
        acc(1'b1, 12'h018, 3'd4, 32'hFF, 32'h0, 1'b1, 1'b0, "R11 flag write");
        acc(1'b0, 12'h044, 3'd4, 32'h0, 32'h0, 1'b1, 1'b0, "R11 clear read");
        rd(12'h030, 32'h2345, "R11 ctrl kept");

        // R6 forbidden mask bits
        acc(1'b1, 12'h038, 3'd4, 32'h0001, 32'h0, 1'b1, 1'b0, "R6 mask bit0");
        acc(1'b1, 12'h038, 3'd4, 32'h0870, 32'h0, 1'b1, 1'b0, "R6 mask bit11");
        rd(12'h038, 32'h0, "R6 mask unchanged");

        // R6/R7/R8 TX unmask schedules evaluation after DLY cycles
        wr(12'h038, 32'h20, "R6 mask tx");
        repeat (DLY - 1) @(negedge clk);
        chk("R7 irq before delay", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq at delay", {31'b0, irq}, 32'h1);
        rd(12'h03C, 32'h20, "R6 raw tx");
        rd(12'h040, 32'h20, "R8 masked tx");

        // R9 clear drops irq next cycle
        wr(12'h044, 32'h20, "R9 clear tx");
        chk("R9 irq low", {31'b0, irq}, 32'h0);
        rd(12'h03C, 32'h0, "R9 raw cleared");
        rd(12'h040, 32'h0, "R9 masked cleared");

        // R4 data write with mask off, R12 end of transmission
        wr(12'h038, 32'h0, "R4 mask off");
        wr(12'h000, 32'h1C3, "R4 data write");
        chk("R4 tx_valid", {31'b0, tx_valid}, 32'h1);
        chk("R4 tx_data", {24'b0, tx_data}, 32'hC3);
        chk("R12 no eot", {31'b0, eot_pulse}, 32'h0);
        @(negedge clk);
        chk("R4 tx_valid one cycle", {31'b0, tx_valid}, 32'h0);
        rd(12'h03C, 32'h20, "R4 raw tx unmasked");
        repeat (DLY + 2) @(negedge clk);
        chk("R8 irq off when masked", {31'b0, irq}, 32'h0);
        wr(12'h000, 32'h04, "R12 eot disabled");
        chk("R12 eot disabled", {31'b0, eot_pulse}, 32'h0);
        eot_enable = 1'b1;
        wr(12'h000, 32'h104, "R12 eot write");
        chk("R12 eot pulse", {31'b0, eot_pulse}, 32'h1);
        chk("R12 eot data", {24'b0, tx_data}, 32'h04);
        @(negedge clk);
        chk("R12 eot one cycle", {31'b0, eot_pulse}, 32'h0);
        eot_enable = 1'b0;

        // R5/R3/R2 receive path
        wr(12'h044, 32'h7FF, "R5 clear all");
        wr(12'h038, 32'h10, "R5 mask rx");
        rx_data = 8'hA5; rx_valid = 1'b1;
        @(negedge clk);
        repeat (DLY - 1) @(negedge clk);
        chk("R5 irq before delay", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R5 irq at delay", {31'b0, irq}, 32'h1);
        rd(12'h03C, 32'h50, "R5 raw rx rt");
        rd(12'h040, 32'h10, "R8 masked rx");
        rd(12'h018, 32'h81, "R2 flags pending");
        acc(1'b0, 12'h000, 3'd4, 32'h0, 32'hA5, 1'b0, 1'b1, "R3 data read");
        rx_valid = 1'b0;
        rd(12'h000, 32'h0, "R3 data read empty");

        // R7 no restart while pending
        wr(12'h044, 32'h7FF, "R7 clear all");
        chk("R7 irq cleared", {31'b0, irq}, 32'h0);
        wr(12'h038, 32'h20, "R7 arm");
        wr(12'h000, 32'h11, "R7 retrigger");
        repeat (DLY - 2) @(negedge clk);
        chk("R7 no early irq", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq not delayed", {31'b0, irq}, 32'h1);

        // R9 clear on the evaluation edge wins
        wr(12'h044, 32'h7FF, "R9 clear all");
        wr(12'h038, 32'h20, "R9 arm");
        repeat (DLY - 1) @(negedge clk);
        wr(12'h044, 32'h20, "R9 clear at eval");
        chk("R9 irq stays low", {31'b0, irq}, 32'h0);
        rd(12'h040, 32'h0, "R9 masked after race");
        repeat (DLY + 1) @(negedge clk);
        chk("R9 irq still low", {31'b0, irq}, 32'h0);

        #5;
        chk("scoreboard drained", sbq.size(), 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule